// File: doc/BRIEF.md
# TMDS Video Link Receiver

This block takes the three serial colour lanes of a 640x480, 60 Hz DVI/HDMI link and turns them back into pixels. Each lane is sampled once per bit-clock edge, where the bit clock runs at ten times the pixel clock (250 MHz against 25 MHz at this resolution). The phase between the serial bits and the pixel clock is not known, so each lane searches for its own 10-bit symbol boundary at run time. It moves the boundary one bit at a time until blanking control tokens appear in an unbroken run.

Each lane has a small gray-pointer FIFO that carries the raw 10-bit symbols from the bit-clock domain into the pixel-clock domain. In the pixel domain, data symbols are decoded into 8-bit colour values. Control tokens on the blue lane give the two sync bits, and data-enable marks the active-video periods. A lane that goes too long without seeing any control token drops its lock and starts its boundary search again.

Top module: `tmds_rx`

## Requirements
- R1: Each lane is deserialised least significant bit first. Exactly one 10-bit symbol is produced every ten bit-clock cycles, and two symbol strobes are never adjacent.
- R2: The control tokens are 0x354, 0x0AB, 0x154 and 0x2AB. A lane declares lock after LOCK_RUN consecutive symbols that are control tokens. `locked` rises only when all three lanes are locked, and stays low from reset until then.
- R3: While a lane is unlocked, every symbol that is not a control token moves its word boundary one bit earlier. This lets the lane lock from any starting bit offset.
- R4: A locked lane that receives LOSS_WORDS consecutive non-token symbols drops its lock and restarts alignment. It locks again once tokens return, even if they arrive at a new bit offset.
- R5: The symbols of each lane cross into the pixel domain through a gray-coded FIFO with 2**FIFO_AW entries. With the bit clock at ten times the pixel clock, this FIFO never receives a write while it is full, and no symbol is lost.
- R6: Lane 0 carries blue, lane 1 carries green and lane 2 carries red. In a data symbol, bit 9 set means bits 7:0 are inverted first. Bit 8 then selects XOR chaining (1) or XNOR chaining (0), with output bit i rebuilt from stored bits i and i-1, and output bit 0 taken directly.
- R7: A blue-lane control token sets {vsync, hsync} as follows: 0x354 gives 00, 0x0AB gives 01, 0x154 gives 10 and 0x2AB gives 11. During data periods both sync outputs hold their last value.
- R8: `de` is high only while the link is locked and the blue lane carries a data symbol. While `de` is low, all three colour outputs are zero.
- R9: During reset, all pixel outputs, `de`, the sync outputs and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial sampling clock, ten times the pixel rate |
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lane_in | input | 3 | Serial bits: [0] blue, [1] green, [2] red |
| red_o | output | 8 | Decoded red value |
| green_o | output | 8 | Decoded green value |
| blue_o | output | 8 | Decoded blue value |
| hsync_o | output | 1 | Horizontal sync from blue control tokens |
| vsync_o | output | 1 | Vertical sync from blue control tokens |
| de_o | output | 1 | Active-video indicator |
| locked_o | output | 1 | All three lanes aligned (pixel domain) |

## Verification
The bench builds the receiver with LOCK_RUN=4, LOSS_WORDS=16 and an 8-entry FIFO. With these values, lock arrives after a handful of symbols, and loss of lock is reached by a data run of only sixteen symbols. This makes it practical to sweep all 256 byte values in both inversion polarities, interleaved with rotating control tokens. The link starts at an odd bit offset, and a further bit of offset is injected after a forced loss of lock, so both the initial boundary search and the re-alignment are exercised.

// File: rtl/tmds_rx_pkg.sv
package tmds_rx_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int NLANES = 3;

  function automatic logic is_ctrl(input logic [SYM_W-1:0] w);
    return (w == 10'h354) || (w == 10'h0AB) || (w == 10'h154) || (w == 10'h2AB);
  endfunction

  function automatic logic [1:0] ctrl_bits(input logic [SYM_W-1:0] w);
    case (w)
      10'h0AB: return 2'b01;
      10'h154: return 2'b10;
      10'h2AB: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] dec_data(input logic [SYM_W-1:0] w);
    logic [BYTE_W-1:0] q, d;
    q = w[9] ? ~w[7:0] : w[7:0];
    d[0] = q[0];
    for (int i = 1; i < BYTE_W; i++)
      d[i] = w[8] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return d;
  endfunction

  function automatic logic [7:0] bin2gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/tmds_rx_lane.sv
module tmds_rx_lane
  import tmds_rx_pkg::*;
#(
  parameter int LOCK_RUN   = 8,
  parameter int LOSS_WORDS = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [SYM_W-1:0] word_o,
  output logic             word_stb_o,
  output logic             locked_o
);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int MISS_W = $clog2(LOSS_WORDS + 1);

  logic [SYM_W-1:0]  sh, sh_next;
  logic [3:0]        cnt;
  logic [RUN_W-1:0]  run;
  logic [MISS_W-1:0] miss;
  logic              tok_hit, miss_ev, slip_ev;

  assign sh_next = {bit_in, sh[SYM_W-1:1]};
  assign tok_hit = word_stb_o && is_ctrl(word_o);
  assign miss_ev = word_stb_o && !is_ctrl(word_o);
  assign slip_ev = miss_ev && !locked_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; word_o <= '0; word_stb_o <= 1'b0;
    end else begin
      sh <= sh_next;
      word_stb_o <= (cnt == 4'd9);
      if (cnt == 4'd9) begin
        word_o <= sh_next;
        cnt    <= '0;
      end else begin
        cnt <= cnt + (slip_ev ? 4'd2 : 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; miss <= '0; locked_o <= 1'b0;
    end else if (!locked_o) begin
      if (tok_hit) begin
        if (run == RUN_W'(LOCK_RUN - 1)) begin
          locked_o <= 1'b1; run <= '0; miss <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else if (miss_ev) begin
        run <= '0;
      end
    end else begin
      if (tok_hit) miss <= '0;
      else if (miss_ev) begin
        if (miss == MISS_W'(LOSS_WORDS - 1)) begin
          locked_o <= 1'b0; miss <= '0; run <= '0;
        end else begin
          miss <= miss + 1'b1;
        end
      end
    end
  end

  AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |=> !word_stb_o); // R1
  AST_LOCK_ON_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(tok_hit)); // R2
  AST_UNLOCK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(miss_ev)); // R4
endmodule

// File: rtl/tmds_rx_cdc.sv
module tmds_rx_cdc
  import tmds_rx_pkg::*;
#(
  parameter int W  = 10,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         rd_valid,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   rg_s1, rg_s2, wg_s1, wg_s2;
  logic          full, empty;

  assign full  = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign empty = (rgray == wg_s2);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg_s1 <= '0; rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray; rg_s2 <= rg_s1;
      if (wr_en && !full) begin
        mem[wbin[AW-1:0]] <= wdata;
        wbin  <= wbin + 1'b1;
        wgray <= (AW+1)'(bin2gray(8'(wbin + 1'b1)));
      end
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg_s1 <= '0; wg_s2 <= '0;
      rd_valid <= 1'b0; rdata <= '0;
    end else begin
      wg_s1 <= wgray; wg_s2 <= wg_s1;
      rd_valid <= !empty;
      if (!empty) begin
        rdata <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= (AW+1)'(bin2gray(8'(rbin + 1'b1)));
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_en |-> !full); // R5
endmodule

// File: rtl/tmds_rx_decode.sv
module tmds_rx_decode
  import tmds_rx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         locked_i,
  input  logic [NLANES-1:0]            valid_i,
  input  logic [NLANES-1:0][SYM_W-1:0] words_i,
  output logic [BYTE_W-1:0]            blue_o,
  output logic [BYTE_W-1:0]            green_o,
  output logic [BYTE_W-1:0]            red_o,
  output logic                         hsync_o,
  output logic                         vsync_o,
  output logic                         de_o
);
  logic [NLANES-1:0][SYM_W-1:0] cur;
  logic                         blue_ctrl;

  assign blue_ctrl = is_ctrl(cur[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else begin
      for (int l = 0; l < NLANES; l++)
        if (valid_i[l]) cur[l] <= words_i[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blue_o <= '0; green_o <= '0; red_o <= '0;
      hsync_o <= 1'b0; vsync_o <= 1'b0; de_o <= 1'b0;
    end else if (!locked_i) begin
      blue_o <= '0; green_o <= '0; red_o <= '0;
      hsync_o <= 1'b0; vsync_o <= 1'b0; de_o <= 1'b0;
    end else if (blue_ctrl) begin
      {vsync_o, hsync_o} <= ctrl_bits(cur[0]);
      blue_o <= '0; green_o <= '0; red_o <= '0;
      de_o <= 1'b0;
    end else begin
      blue_o  <= dec_data(cur[0]);
      green_o <= dec_data(cur[1]);
      red_o   <= dec_data(cur[2]);
      de_o    <= 1'b1;
    end
  end

  AST_SYNC_HOLD_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && $past(de_o)) |-> $stable({vsync_o, hsync_o})); // R7
  AST_DE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> $past(locked_i)); // R8
endmodule

// File: rtl/tmds_rx.sv
module tmds_rx
  import tmds_rx_pkg::*;
#(
  parameter int LOCK_RUN   = 8,
  parameter int LOSS_WORDS = 4096,
  parameter int FIFO_AW    = 3
) (
  input  logic              bit_clk,
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic [NLANES-1:0] lane_in,
  output logic [BYTE_W-1:0] red_o,
  output logic [BYTE_W-1:0] green_o,
  output logic [BYTE_W-1:0] blue_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              locked_o
);
  logic [NLANES-1:0][SYM_W-1:0] lane_word, pix_word;
  logic [NLANES-1:0]            lane_stb, lane_lock, pix_valid;
  logic [NLANES-1:0]            lk_s1, lk_s2;
  logic                         all_locked;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    tmds_rx_lane #(.LOCK_RUN(LOCK_RUN), .LOSS_WORDS(LOSS_WORDS)) u_lane (
      .clk(bit_clk), .rst_n(rst_n), .bit_in(lane_in[l]),
      .word_o(lane_word[l]), .word_stb_o(lane_stb[l]), .locked_o(lane_lock[l]));
    tmds_rx_cdc #(.W(SYM_W), .AW(FIFO_AW)) u_cdc (
      .wclk(bit_clk), .rclk(pix_clk), .rst_n(rst_n),
      .wr_en(lane_stb[l]), .wdata(lane_word[l]),
      .rd_valid(pix_valid[l]), .rdata(pix_word[l]));
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s1 <= '0; lk_s2 <= '0; locked_o <= 1'b0;
    end else begin
      lk_s1 <= lane_lock; lk_s2 <= lk_s1;
      locked_o <= &lk_s2;
    end
  end

  assign all_locked = &lk_s2;

  tmds_rx_decode u_dec (
    .clk(pix_clk), .rst_n(rst_n), .locked_i(all_locked),
    .valid_i(pix_valid), .words_i(pix_word),
    .blue_o(blue_o), .green_o(green_o), .red_o(red_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o));

  AST_LOCK_RESET_LOW: assert property (@(posedge pix_clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(&lk_s1)); // R2
endmodule

// File: tb/tb_tmds_rx.sv
module tb_tmds_rx;
  logic       bit_clk = 1'b0, pix_clk = 1'b0, rst_n = 1'b0;
  logic [2:0] lane_in;
  logic [7:0] red_o, green_o, blue_o;
  logic       hsync_o, vsync_o, de_o, locked_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [9:0] tx [3];
  int extra_bits = 3;
  logic [9:0] toks [4];

  tmds_rx #(.LOCK_RUN(4), .LOSS_WORDS(16), .FIFO_AW(3)) dut (
    .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n), .lane_in(lane_in),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .locked_o(locked_o));

  always #5 bit_clk = ~bit_clk;
  initial begin #3; forever #50 pix_clk = ~pix_clk; end

  function automatic logic [9:0] encode(input logic [7:0] d, input logic inv);
    int n = 0;
    logic use_xor;
    logic [7:0] q;
    for (int i = 0; i < 8; i++) n += int'(d[i]);
    use_xor = !((n > 4) || (n == 4 && !d[0]));
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = use_xor ? (q[i-1] ^ d[i]) : ~(q[i-1] ^ d[i]);
    return {inv, use_xor, inv ? ~q : q};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_pix(input int n);
    repeat (n) @(negedge pix_clk);
  endtask

  task automatic set_all(input logic [9:0] b, input logic [9:0] g, input logic [9:0] r);
    tx[0] = b; tx[1] = g; tx[2] = r;
  endtask

  // serial sender: LSB first, one word per pixel period
  initial begin
    logic [9:0] snap [3];
    lane_in = '0;
    forever begin
      if (extra_bits > 0) begin
        @(negedge bit_clk); lane_in = 3'b101; extra_bits--;
      end else begin
        snap = tx;
        for (int i = 0; i < 10; i++) begin
          @(negedge bit_clk);
          for (int l = 0; l < 3; l++) lane_in[l] = snap[l][i];
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge bit_clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
      finish_run();
    end
  end

  initial begin
    int prev;
    toks[0] = 10'h354; toks[1] = 10'h0AB; toks[2] = 10'h154; toks[3] = 10'h2AB;
    set_all(toks[0], toks[0], toks[0]);
    wait_pix(5);
    check("R9 locked in reset", 32'(locked_o), 0);
    check("R9 de in reset", 32'(de_o), 0);
    check("R9 pixels in reset", {8'h0, red_o, green_o, blue_o}, 0);
    check("R9 sync in reset", {30'h0, vsync_o, hsync_o}, 0);
    rst_n = 1'b1;
    wait_pix(1);
    check("R2 not yet locked", 32'(locked_o), 0);
    wait_pix(40);
    check("R2 R3 locked from offset start", 32'(locked_o), 1);

    for (int t = 0; t < 4; t++) begin
      set_all(toks[t], toks[(t+1)%4], toks[(t+2)%4]);
      wait_pix(9);
      check("R7 sync from blue token", {30'h0, vsync_o, hsync_o}, 32'(t));
      check("R8 de low in control", 32'(de_o), 0);
      check("R8 pixels zero in control", {8'h0, red_o, green_o, blue_o}, 0);
    end

    prev = 3;
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b, g, r;
        b = 8'(v); g = 8'(v) ^ 8'h5A; r = ~8'(v);
        set_all(encode(b, 1'(inv)), encode(g, 1'(~inv)), encode(r, 1'(inv)));
        wait_pix(9);
        check("R1 R6 blue", 32'(blue_o), 32'(b));
        check("R6 green", 32'(green_o), 32'(g));
        check("R5 R6 red", 32'(red_o), 32'(r));
        check("R8 de in data", 32'(de_o), 1);
        check("R7 sync held in data", {30'h0, vsync_o, hsync_o}, 32'(prev));
        prev = v % 4;
        set_all(toks[prev], toks[0], toks[0]);
        wait_pix(3);
      end
    end

    set_all(encode(8'h10, 1'b0), encode(8'h10, 1'b0), encode(8'h10, 1'b0));
    wait_pix(30);
    check("R4 lock lost after long data run", 32'(locked_o), 0);
    check("R4 de low when unlocked", 32'(de_o), 0);
    extra_bits = 1;
    set_all(toks[0], toks[0], toks[0]);
    wait_pix(40);
    check("R4 relocked after tokens", 32'(locked_o), 1);
    set_all(encode(8'hA5, 1'b1), encode(8'h3C, 1'b0), encode(8'hC3, 1'b1));
    wait_pix(9);
    check("R3 blue after shifted realign", 32'(blue_o), 32'h0A5);
    check("R3 green after shifted realign", 32'(green_o), 32'h03C);
    check("R3 red after shifted realign", 32'(red_o), 32'h0C3);
    finish_run();
  end
endmodule